// File: doc/BRIEF.md
# Shadow-Backed Static RAM Controller

This block models a small static RAM, 256 words of 4 bits, that has a nonvolatile shadow array behind it. Ordinary access uses active-low select and write-enable controls: a read shows the addressed word in the same cycle, and a write lands at the next clock edge. Two active-low commands move the whole array in one direction or the other. The save command copies working RAM into the shadow. The restore command copies the shadow back into working RAM. Each transfer moves one word per clock and holds `busy` high until it finishes.

Bulk transfers take priority over normal access and cut it short. A save that begins while a write is being presented leaves a defined poison value at that address, in both arrays. A restore runs automatically after reset, before any access is accepted. The save command passes through a pulse-width filter. Both commands are edge-qualified. Restore wins over save. A power-good input freezes everything while it is low. Save is given a parameterised total length, much longer than the 256-cycle restore.

Top module: `nvsram_ctrl`

## Requirements
- R1: While idle and powered, with `cs_n`=0 and `we_n`=1, `dout_en` is 1 and `dout` equals the addressed working-RAM word in the same cycle. With `cs_n`=1, `dout_en` is 0.
- R2: While idle and powered, with `cs_n`=0 and `we_n`=0, `din` is written to the addressed word at the clock edge and can be read back on the following cycle.
- R3: After `rst_n` is released, `busy` stays high for exactly 256 sampled cycles (the release cycle included) while the shadow array is copied into working RAM. Stored data survives a reset.
- R4: If `save_n`, sampled low at `SAVE_MIN_LOW` consecutive edges (3 in the test setup), reaches the last of those edges while the block is idle, a save starts. `busy` then stays high for `SAVE_CYCLES` cycles, and the shadow ends up holding the working-RAM contents.
- R5: A `save_n` low pulse seen at fewer than `SAVE_MIN_LOW` edges starts nothing.
- R6: If `restore_n` is sampled low while the block is idle, a restore starts. `busy` stays high for 256 cycles, and working RAM ends up equal to the shadow.
- R7: While `busy` is high, `dout_en` is 0. Writes are ignored. A `restore_n` pulse during a save is ignored and leaves nothing pending.
- R8: If a save starts in a cycle that presents a write, the addressed word becomes `POISON_VAL` (5 in the test setup) in working RAM, and after the copy in the shadow as well.
- R9: If both commands become valid in the same cycle, the restore runs. While `restore_n` is held low, a save cannot start.
- R10: A command line held low after its transfer completes does not start another transfer. The line must return high first.
- R11: While `pwr_good` is 0, `dout_en` is 0, writes are ignored, no command is accepted and a running transfer pauses. A `save_n` already low when power returns does not start a save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release starts the automatic restore |
| pwr_good | input | 1 | High when supply is valid; low inhibits all functions |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not enabled |
| dout_en | output | 1 | High when `dout` carries valid read data |
| save_n | input | 1 | Active-low save command (RAM to shadow), pulse-filtered |
| restore_n | input | 1 | Active-low restore command (shadow to RAM) |
| busy | output | 1 | High while a bulk transfer is running |

## Verification
Every cycle, the assertions check the following:
- the output stays disabled when deselected, unpowered or busy;
- `busy` is high on the first cycle after reset;
- a save never starts without `save_n` having been low for the minimum run, nor while `restore_n` is low or a restore is starting;
- no transfer starts, and none advances out of busy, without power.

Only the bench scenarios can show the following:
- data actually moves between the two arrays and survives a reset;
- transfer lengths are exact;
- a write that a save cuts off leaves the poison value in both arrays;
- a transfer paused by a power drop resumes and ends the correct number of cycles later.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      XS_IDLE    = 2'd0,
      XS_RESTORE = 2'd1,
      XS_SAVE    = 2'd2
   } xfer_state_e;
endpackage

// File: rtl/nvs_cmd_filter.sv
// Edge-qualified command filter: fires once when the active-low line has
// been sampled low at MIN_LOW consecutive edges after being seen high
// while enabled. Disabled (power lost) clears the arming.
module nvs_cmd_filter #(
   parameter int MIN_LOW = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cmd_n,
   output logic fire
);
   if (MIN_LOW < 1) begin : g_bad_min
      $error("nvs_cmd_filter: MIN_LOW must be at least 1");
   end

   logic armed_q;

   if (MIN_LOW == 1) begin : g_direct
      assign fire = enable && armed_q && !cmd_n;
   end else begin : g_counted
      localparam int CW = $clog2(MIN_LOW);
      logic [CW-1:0] run_q;
      assign fire = enable && armed_q && !cmd_n && (run_q == CW'(MIN_LOW - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
         end else if (!enable || cmd_n) begin
            run_q <= '0;
         end else if (run_q != CW'(MIN_LOW - 1)) begin
            run_q <= run_q + CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (!enable) begin
         armed_q <= 1'b0;
      end else if (cmd_n) begin
         armed_q <= 1'b1;
      end else if (fire) begin
         armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/nvs_word_array.sv
// Register-based word store: one synchronous write port, one
// combinational read port. Deliberately not reset (holds data).
module nvs_word_array #(
   parameter int AW = 8,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvs_xfer_seq.sv
// Bulk transfer sequencer: arbitrates the two commands, walks the word
// pointer, pads a save to SAVE_CYCLES and pauses when run is low.
module nvs_xfer_seq
   import nvs_pkg::*;
#(
   parameter int AW          = 8,
   parameter int SAVE_CYCLES = 4096
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          save_fire,
   input  logic          restore_fire,
   input  logic          restore_n,
   output xfer_state_e   state,
   output logic [AW-1:0] ptr,
   output logic          start_save,
   output logic          start_restore,
   output logic          copy_save,
   output logic          copy_restore
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = $clog2(SAVE_CYCLES);

   if (SAVE_CYCLES < DEPTH) begin : g_bad_len
      $error("nvs_xfer_seq: SAVE_CYCLES must cover every word");
   end

   xfer_state_e   state_q;
   logic [CW-1:0] cnt_q;
   logic          in_copy;
   logic          last_restore;
   logic          last_save;
   logic          idle;

   if (CW > AW) begin : g_padded
      assign in_copy = (cnt_q[CW-1:AW] == '0);
   end else begin : g_unpadded
      assign in_copy = 1'b1;
   end

   assign idle          = (state_q == XS_IDLE);
   assign last_restore  = (cnt_q[AW-1:0] == {AW{1'b1}});
   assign last_save     = (cnt_q == CW'(SAVE_CYCLES - 1));
   assign start_restore = idle && run && restore_fire;
   assign start_save    = idle && run && save_fire && restore_n && !restore_fire;
   assign copy_restore  = (state_q == XS_RESTORE) && run;
   assign copy_save     = (state_q == XS_SAVE) && run && in_copy;
   assign ptr           = cnt_q[AW-1:0];
   assign state         = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_RESTORE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            XS_IDLE: begin
               if (start_restore) begin
                  state_q <= XS_RESTORE;
                  cnt_q   <= '0;
               end else if (start_save) begin
                  state_q <= XS_SAVE;
                  cnt_q   <= '0;
               end
            end
            XS_RESTORE: begin
               if (run) begin
                  if (last_restore) begin
                     state_q <= XS_IDLE;
                  end else begin
                     cnt_q <= cnt_q + CW'(1);
                  end
               end
            end
            XS_SAVE: begin
               if (run) begin
                  if (last_save) begin
                     state_q <= XS_IDLE;
                  end else begin
                     cnt_q <= cnt_q + CW'(1);
                  end
               end
            end
            default: begin
               state_q <= XS_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
   import nvs_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 4,
   parameter int SAVE_CYCLES    = 4096,
   parameter int SAVE_MIN_LOW   = 3,
   parameter int POISON_VAL     = 5,
   parameter bit POISON_UNKNOWN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   input  logic              save_n,
   input  logic              restore_n,
   output logic              busy
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
      $error("nvsram_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("nvsram_ctrl: DATA_W must be positive");
   end

   xfer_state_e       state;
   logic [ADDR_W-1:0] ptr;
   logic              save_fire;
   logic              restore_fire;
   logic              start_save;
   logic              start_restore;
   logic              copy_save;
   logic              copy_restore;
   logic              idle;
   logic              access_ok;
   logic              user_wr;
   logic              poison_wr;
   logic [DATA_W-1:0] poison_word;

   logic              ram_we;
   logic [ADDR_W-1:0] ram_wa;
   logic [DATA_W-1:0] ram_wd;
   logic [ADDR_W-1:0] ram_ra;
   logic [DATA_W-1:0] ram_rd;
   logic [DATA_W-1:0] shadow_rd;

   if (POISON_UNKNOWN) begin : g_poison_x
      assign poison_word = 'x;
   end else begin : g_poison_val
      assign poison_word = DATA_W'(POISON_VAL);
   end

   nvs_cmd_filter #(.MIN_LOW(SAVE_MIN_LOW)) u_save_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (pwr_good),
      .cmd_n  (save_n),
      .fire   (save_fire)
   );

   nvs_cmd_filter #(.MIN_LOW(1)) u_restore_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (pwr_good),
      .cmd_n  (restore_n),
      .fire   (restore_fire)
   );

   nvs_xfer_seq #(.AW(ADDR_W), .SAVE_CYCLES(SAVE_CYCLES)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (pwr_good),
      .save_fire     (save_fire),
      .restore_fire  (restore_fire),
      .restore_n     (restore_n),
      .state         (state),
      .ptr           (ptr),
      .start_save    (start_save),
      .start_restore (start_restore),
      .copy_save     (copy_save),
      .copy_restore  (copy_restore)
   );

   assign idle      = (state == XS_IDLE);
   assign busy      = !idle;
   assign access_ok = idle && pwr_good && !cs_n && !start_save && !start_restore;
   assign dout_en   = access_ok && we_n;
   assign user_wr   = access_ok && !we_n;
   assign poison_wr = start_save && !cs_n && !we_n;
   assign dout      = dout_en ? ram_rd : '0;
   assign ram_ra    = idle ? addr : ptr;

   always_comb begin
      ram_we = 1'b0;
      ram_wa = addr;
      ram_wd = din;
      if (copy_restore) begin
         ram_we = 1'b1;
         ram_wa = ptr;
         ram_wd = shadow_rd;
      end else if (poison_wr) begin
         ram_we = 1'b1;
         ram_wd = poison_word;
      end else if (user_wr) begin
         ram_we = 1'b1;
      end
   end

   nvs_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk     (clk),
      .wr_en   (ram_we),
      .wr_addr (ram_wa),
      .wr_data (ram_wd),
      .rd_addr (ram_ra),
      .rd_data (ram_rd)
   );

   nvs_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
      .clk     (clk),
      .wr_en   (copy_save),
      .wr_addr (ptr),
      .wr_data (ram_rd),
      .rd_addr (ptr),
      .rd_data (shadow_rd)
   );
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk #(
   parameter int SAVE_MIN_LOW = 3
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_good,
   input logic cs_n,
   input logic save_n,
   input logic restore_n,
   input logic dout_en,
   input logic busy,
   input logic start_save,
   input logic start_restore
);
   if (SAVE_MIN_LOW > 255) begin : g_bad_min
      $error("nvsram_ctrl_chk: SAVE_MIN_LOW too large for the run counter");
   end

   logic [7:0] lowrun_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowrun_q <= '0;
      end else if (save_n || !pwr_good) begin
         lowrun_q <= '0;
      end else if (lowrun_q != 8'hFF) begin
         lowrun_q <= lowrun_q + 8'd1;
      end
   end

   AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !dout_en); // R1
   AST_BUSY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> busy); // R3
   AST_SAVE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      start_save |-> (!save_n && lowrun_q >= 8'(SAVE_MIN_LOW - 1))); // R5
   AST_NO_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dout_en); // R7
   AST_RESTORE_BEATS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      start_save |-> (restore_n && !start_restore)); // R9
   AST_NO_DRIVE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |-> !dout_en); // R11
   AST_NO_START_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_save || start_restore) |-> pwr_good); // R11
   AST_PAUSE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pwr_good) |=> busy); // R11
endmodule

bind nvsram_ctrl nvsram_ctrl_chk #(.SAVE_MIN_LOW(SAVE_MIN_LOW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pwr_good      (pwr_good),
   .cs_n          (cs_n),
   .save_n        (save_n),
   .restore_n     (restore_n),
   .dout_en       (dout_en),
   .busy          (busy),
   .start_save    (start_save),
   .start_restore (start_restore)
);

// File: tb/nvsram_ctrl_test.sv
module nvsram_ctrl_test;
   localparam int SAVE_CYC = 600;
   localparam int RESTORE_CYC = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_good = 1'b1;
   logic       cs_n = 1'b1;
   logic       we_n = 1'b1;
   logic [7:0] addr = '0;
   logic [3:0] din = '0;
   logic [3:0] dout;
   logic       dout_en;
   logic       save_n = 1'b1;
   logic       restore_n = 1'b1;
   logic       busy;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   nvsram_ctrl #(
      .ADDR_W(8), .DATA_W(4), .SAVE_CYCLES(SAVE_CYC),
      .SAVE_MIN_LOW(3), .POISON_VAL(5), .POISON_UNKNOWN(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .save_n(save_n), .restore_n(restore_n), .busy(busy)
   );

   // {op[1:0], addr[7:0], data[3:0], expected[3:0]}; op 0 write, 1 read, 2 deselected
   localparam logic [17:0] VEC [12] = '{
      {2'd0, 8'h00, 4'h3, 4'h0},
      {2'd0, 8'h01, 4'hC, 4'h0},
      {2'd0, 8'h7F, 4'h9, 4'h0},
      {2'd0, 8'hFF, 4'hE, 4'h0},
      {2'd0, 8'h03, 4'h6, 4'h0},
      {2'd1, 8'h00, 4'h0, 4'h3},
      {2'd1, 8'hFF, 4'h0, 4'hE},
      {2'd2, 8'h01, 4'h0, 4'h0},
      {2'd1, 8'h01, 4'h0, 4'hC},
      {2'd1, 8'h7F, 4'h0, 4'h9},
      {2'd1, 8'h03, 4'h0, 4'h6},
      {2'd0, 8'h7F, 4'h2, 4'h0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] d);
      cs_n = 1'b0; we_n = 1'b0; addr = a; din = d;
      cyc(1);
      cs_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd(input logic [7:0] a, input int exp, input string req);
      cs_n = 1'b0; we_n = 1'b1; addr = a;
      #1;
      chk({req, " dout_en"}, int'(dout_en), 1);
      chk({req, " dout"}, int'(dout), exp);
      cyc(1);
      cs_n = 1'b1;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         cyc(1);
      end
   endtask

   task automatic restore_cmd();
      restore_n = 1'b0;
      cyc(1);
      restore_n = 1'b1;
   endtask

   task automatic save_pulse(input int samples);
      save_n = 1'b0;
      cyc(samples);
      save_n = 1'b1;
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      cyc(5);
      chk("R7 reset dout_en", int'(dout_en), 0);
      rst_n = 1'b1;
      #1;
      wait_idle(n);
      chk("R3 auto restore length", n, RESTORE_CYC);

      // table walk: R1 reads, R2 writes
      for (int i = 0; i < 12; i++) begin
         if (VEC[i][17:16] == 2'd0) begin
            wr(VEC[i][15:8], VEC[i][7:4]);
         end else if (VEC[i][17:16] == 2'd1) begin
            rd(VEC[i][15:8], int'(VEC[i][3:0]), "R1 R2 table read");
         end else begin
            cs_n = 1'b1; we_n = 1'b1; addr = VEC[i][15:8];
            #1;
            chk("R1 deselected dout_en", int'(dout_en), 0);
            cyc(1);
         end
      end
      rd(8'h7F, 4'h2, "R2 overwrite");

      // R5: short pulse
      save_pulse(2);
      cyc(3);
      chk("R5 short pulse no save", int'(busy), 0);

      // R4: valid save, R10: line held low afterwards
      save_n = 1'b0;
      cyc(3);
      wait_idle(n);
      chk("R4 save length", n, SAVE_CYC);
      cyc(5);
      chk("R10 held save no retrigger", int'(busy), 0);
      save_n = 1'b1;
      cyc(1);

      // R6: restore brings back saved data
      wr(8'h00, 4'h0);
      wr(8'hFF, 4'h0);
      restore_cmd();
      wait_idle(n);
      chk("R6 restore length", n, RESTORE_CYC);
      rd(8'h00, 4'h3, "R6 R4 restored word 00");
      rd(8'hFF, 4'hE, "R6 R4 restored word FF");

      // R7: access ignored during save
      save_pulse(3);
      chk("R7 save started", int'(busy), 1);
      cs_n = 1'b0; we_n = 1'b1; addr = 8'h01;
      #1;
      chk("R7 no read while busy", int'(dout_en), 0);
      cyc(1);
      we_n = 1'b0; addr = 8'h03; din = 4'hF;
      cyc(1);
      cs_n = 1'b1; we_n = 1'b1;
      restore_n = 1'b0;
      cyc(1);
      restore_n = 1'b1;
      wait_idle(n);
      cyc(3);
      chk("R7 restore during save ignored", int'(busy), 0);
      rd(8'h03, 4'h6, "R7 write during save ignored");

      // R8: save cuts off a write
      cs_n = 1'b0; we_n = 1'b0; addr = 8'h10; din = 4'h7;
      save_n = 1'b0;
      cyc(3);
      cs_n = 1'b1; we_n = 1'b1; save_n = 1'b1;
      wait_idle(n);
      rd(8'h10, 5, "R8 poison in RAM");
      wr(8'h10, 4'h9);
      restore_cmd();
      wait_idle(n);
      rd(8'h10, 5, "R8 poison in shadow");

      // R9: both valid in the same cycle
      save_n = 1'b0;
      cyc(2);
      restore_n = 1'b0;
      cyc(1);
      restore_n = 1'b1;
      wait_idle(n);
      chk("R9 restore wins", n, RESTORE_CYC);
      save_n = 1'b1;
      cyc(1);

      // R9: restore held low blocks save
      restore_n = 1'b0;
      cyc(1);
      wait_idle(n);
      save_pulse(3);
      cyc(2);
      chk("R9 held restore blocks save", int'(busy), 0);
      restore_n = 1'b1;
      cyc(1);

      // R11: power-good inhibits
      wr(8'h30, 4'h1);
      pwr_good = 1'b0;
      cs_n = 1'b0; we_n = 1'b1; addr = 8'h30;
      #1;
      chk("R11 no read unpowered", int'(dout_en), 0);
      cyc(1);
      wr(8'h30, 4'hE);
      save_pulse(3);
      cyc(1);
      chk("R11 no save unpowered", int'(busy), 0);
      pwr_good = 1'b1;
      cyc(1);
      rd(8'h30, 4'h1, "R11 write ignored unpowered");
      save_n = 1'b0;
      pwr_good = 1'b0;
      cyc(2);
      pwr_good = 1'b1;
      cyc(5);
      chk("R11 save low at power return", int'(busy), 0);
      save_n = 1'b1;
      cyc(1);
      restore_n = 1'b0;
      cyc(1);
      restore_n = 1'b1;
      n = 0;
      while (busy) begin
         n++;
         if (n == 10) pwr_good = 1'b0;
         if (n == 30) pwr_good = 1'b1;
         cyc(1);
      end
      chk("R11 paused restore length", n, RESTORE_CYC + 20);

      // R3: data survives reset
      wr(8'h01, 4'h0);
      rst_n = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      #1;
      wait_idle(n);
      chk("R3 second auto restore length", n, RESTORE_CYC);
      rd(8'h01, 4'hC, "R3 restored after reset");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule